// File: doc/BRIEF.md
# Buffered Multi-Output PWM Generator

This block turns a prescaled 8-bit up-counter into a pulse-width-modulated waveform and sends it to up to four outputs. Software-style writes go into shadow registers. While the block runs, the active copies are refreshed only when the counter wraps to zero, so a mid-period write can never cut a pulse short or stretch it. The dead-band delay works on a separate schedule. It is taken over at the first duty falling point or at the period wrap, whichever comes first.

A phase counter splits each timer step into four input clocks, so the duty value has two more bits of resolution than the timer. A 2-bit steering field selects one of four arrangements: a single output, a half-bridge pair with dead time, or a full bridge in either direction. A per-output mask makes each output active-low on its own. Deasserting the enable parks the counter and copies the shadows directly. After enable is raised again, the first pulse appears only when the counter next wraps.

Top module: `pwm_multi_out`

## Requirements
- R1: In the clock after synchronous reset, every output sits at its reset-default inactive level, which is 0 for the default parameters. The timer, the phase counter, all shadow copies and all active copies are cleared.
- R2: The PWM period is (P+1)·4·D input clocks. P is the active period value. D is the prescale ratio picked by control bits [1:0]: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R3: The internal pulse is high from the period wrap until the count {timer, phase} reaches the 10-bit duty value, so the high time is duty·D clocks. A duty larger than the last count in the period keeps the pulse high for the whole period.
- R4: A duty of zero gives no pulse at all. The output never becomes active.
- R5: Writes use wr_sel: 0 for period, 1 for duty, 2 for control, 3 for delay. The control byte holds prescale in [1:0], steering in [3:2] and polarity mask in [7:4]. While enabled, a new period, duty or control value takes effect only at the next period wrap. While disabled, it becomes active one clock after it is written.
- R6: A new delay value is adopted at the first duty falling point or period wrap after it is written. At a falling point, the dead time that begins there already uses the new value.
- R7: After enable rises, the outputs stay inactive until the counter first wraps. With P=4, D=1 and duty 9, output A first reads active at the 22nd falling clock edge after enable is driven high.
- R8: Steering 00 drives only A with the pulse. 01 holds A active and drives D with the pulse. 10 drives A with the pulse and B with its complement. 11 holds C active and drives B with the pulse. Outputs not named stay inactive.
- R9: When polarity mask bit i is 1, output i (A=0 … D=3) is active-low. Every inactive output then reads 1.
- R10: In steering 10, each pulse edge starts a dead time of exactly "delay" clocks. During it both A and B are inactive, and A and B are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 duty, 2 control, 3 delay) |
| wr_data | input | 10 | Write data, low bits used per register |
| pwm_out | output | 4 | Outputs A (bit 0) to D (bit 3) after steering and polarity |

## Verification
The hardest case to reach is the delay register loading at the duty falling point instead of at the wrap. The difference shows only if the delay changes between a wrap and the next fall. The stimulus waits for output A to rise in half-bridge mode, writes a new delay during that high phase, and then measures the gap where both A and B are off right after A falls. The write that lands during a high phase of single-output mode is handled the same way: the bench checks that the current pulse keeps its old width and the next pulse takes the new one. A behavioural model checks every clock against the outputs, with the requirement tag taken from the phase under test.

// File: rtl/pwm_mo_pkg.sv
package pwm_mo_pkg;
   typedef enum logic [1:0] {
      OM_SINGLE = 2'b00,
      OM_FWD    = 2'b01,
      OM_HALF   = 2'b10,
      OM_REV    = 2'b11
   } omode_e;

   typedef struct packed {
      logic [3:0] pol;
      omode_e     mode;
      logic [1:0] pre;
   } ctl_t;

   localparam logic [1:0] SEL_PER  = 2'd0;
   localparam logic [1:0] SEL_DUTY = 2'd1;
   localparam logic [1:0] SEL_CTL  = 2'd2;
   localparam logic [1:0] SEL_DEL  = 2'd3;

   localparam int NUM_OUT = 4;
   localparam int PH_W    = 2;
   localparam int PS_W    = 4;
endpackage

// File: rtl/pwm_mo_tick.sv
module pwm_mo_tick
   import pwm_mo_pkg::*;
#(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [1:0]       pre_sel,
   input  logic [TMR_W-1:0] per_a,
   output logic [TMR_W-1:0] tmr,
   output logic [PH_W-1:0]  phase,
   output logic             wrap,
   output logic             run
);
   localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

   logic [PS_W-1:0] ps_cnt;
   logic [PS_W-1:0] ps_max;
   logic            tick;

   always_comb begin
      unique case (pre_sel)
         2'b00:   ps_max = PS_W'(0);
         2'b01:   ps_max = PS_W'(3);
         default: ps_max = PS_W'(15);
      endcase
   end

   assign tick = (ps_cnt == ps_max);
   assign wrap = en && tick && (phase == PH_LAST) && (tmr == per_a);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         ps_cnt <= '0;
         phase  <= '0;
         tmr    <= '0;
         run    <= 1'b0;
      end else begin
         if (tick) begin
            ps_cnt <= '0;
            phase  <= phase + 1'b1;
            if (phase == PH_LAST)
               tmr <= (tmr == per_a) ? '0 : tmr + 1'b1;
         end else begin
            ps_cnt <= ps_cnt + 1'b1;
         end
         if (wrap)
            run <= 1'b1;
      end
   end

   AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      tmr <= per_a) else $error("timer beyond period"); // R2
   AST_RUN_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && !run && !wrap) |=> !run) else $error("run without wrap"); // R7
endmodule

// File: rtl/pwm_mo_regs.sv
module pwm_mo_regs
   import pwm_mo_pkg::*;
#(
   parameter int         TMR_W   = 8,
   parameter int         DEL_W   = 7,
   parameter logic [3:0] RST_POL = 4'b0000,
   localparam int        DUTY_W  = TMR_W + PH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DUTY_W-1:0] wr_data,
   input  logic              wrap,
   input  logic              duty_fall,
   output logic [TMR_W-1:0]  per_a,
   output logic [DUTY_W-1:0] duty_a,
   output ctl_t              ctl_a,
   output logic [DEL_W-1:0]  del_a,
   output logic [DEL_W-1:0]  del_sh
);
   logic [TMR_W-1:0]  per_sh;
   logic [DUTY_W-1:0] duty_sh;
   ctl_t              ctl_sh;
   ctl_t              ctl_rst;

   assign ctl_rst = '{pol: RST_POL, mode: OM_SINGLE, pre: 2'b00};

   always_ff @(posedge clk) begin
      if (rst) begin
         per_sh  <= '0;
         duty_sh <= '0;
         ctl_sh  <= ctl_rst;
         del_sh  <= '0;
         per_a   <= '0;
         duty_a  <= '0;
         ctl_a   <= ctl_rst;
         del_a   <= '0;
      end else begin
         if (wr_en) begin
            unique case (wr_sel)
               SEL_PER:  per_sh  <= wr_data[TMR_W-1:0];
               SEL_DUTY: duty_sh <= wr_data;
               SEL_CTL:  ctl_sh  <= ctl_t'(wr_data[7:0]);
               default:  del_sh  <= wr_data[DEL_W-1:0];
            endcase
         end
         if (!en || wrap) begin
            per_a  <= per_sh;
            duty_a <= duty_sh;
            ctl_a  <= ctl_sh;
            del_a  <= del_sh;
         end else if (duty_fall) begin
            del_a  <= del_sh;
         end
      end
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (en && !wrap) |=> ($stable(duty_a) && $stable(per_a) && $stable(ctl_a)))
      else $error("active setting moved off boundary"); // R5
endmodule

// File: rtl/pwm_mo_steer.sv
module pwm_mo_steer
   import pwm_mo_pkg::*;
#(
   parameter int         DEL_W   = 7,
   parameter logic [3:0] RST_POL = 4'b0000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               run,
   input  logic               raw,
   input  omode_e             mode,
   input  logic [3:0]         pol,
   input  logic [DEL_W-1:0]   del_a,
   input  logic [DEL_W-1:0]   del_sh,
   output logic               duty_fall,
   output logic               phase_q,
   output logic [NUM_OUT-1:0] pwm_out
);
   logic [DEL_W-1:0]   dcnt;
   logic               quiet;
   logic [NUM_OUT-1:0] act;

   assign duty_fall = phase_q && !raw;
   assign quiet     = (dcnt == '0);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         phase_q <= 1'b0;
         dcnt    <= '0;
      end else begin
         phase_q <= raw;
         if (raw != phase_q)
            dcnt <= duty_fall ? del_sh : del_a;
         else if (!quiet)
            dcnt <= dcnt - 1'b1;
      end
   end

   always_comb begin
      unique case (mode)
         OM_SINGLE: act = {3'b000, phase_q};
         OM_FWD:    act = {phase_q, 2'b00, run};
         OM_HALF:   act = {2'b00, run & ~phase_q & quiet, phase_q & quiet};
         default:   act = {1'b0, run, phase_q, 1'b0};
      endcase
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
      always_ff @(posedge clk) begin
         if (rst) pwm_out[i] <= RST_POL[i];
         else     pwm_out[i] <= act[i] ^ pol[i];
      end
   end

   AST_HALF_EXCL: assert property (@(posedge clk) disable iff (rst)
      (mode == OM_HALF) |-> !(act[0] && act[1])) else $error("pair overlap"); // R10
   AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
      !run |-> (act == '0)) else $error("active before first wrap"); // R7
endmodule

// File: rtl/pwm_multi_out.sv
module pwm_multi_out
   import pwm_mo_pkg::*;
#(
   parameter int         TMR_W   = 8,
   parameter int         DEL_W   = 7,
   parameter logic [3:0] RST_POL = 4'b0000,
   localparam int        DUTY_W  = TMR_W + PH_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [DUTY_W-1:0]  wr_data,
   output logic [NUM_OUT-1:0] pwm_out
);
   if (DUTY_W < 8) begin : g_bad_width
      $error("duty width must hold the 8-bit control byte");
   end
   if (DEL_W > DUTY_W || DEL_W < 1) begin : g_bad_delay
      $error("delay width out of range");
   end

   logic [TMR_W-1:0]  per_a;
   logic [DUTY_W-1:0] duty_a;
   ctl_t              ctl_a;
   logic [DEL_W-1:0]  del_a;
   logic [DEL_W-1:0]  del_sh;
   logic [TMR_W-1:0]  tmr;
   logic [PH_W-1:0]   phase;
   logic              wrap;
   logic              run;
   logic              raw;
   logic              duty_fall;
   logic              phase_q;

   pwm_mo_tick #(.TMR_W(TMR_W)) u_tick (
      .clk(clk), .rst(rst), .en(en), .pre_sel(ctl_a.pre), .per_a(per_a),
      .tmr(tmr), .phase(phase), .wrap(wrap), .run(run)
   );

   pwm_mo_regs #(.TMR_W(TMR_W), .DEL_W(DEL_W), .RST_POL(RST_POL)) u_regs (
      .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wrap(wrap), .duty_fall(duty_fall),
      .per_a(per_a), .duty_a(duty_a), .ctl_a(ctl_a), .del_a(del_a),
      .del_sh(del_sh)
   );

   assign raw = run && ({tmr, phase} < duty_a);

   pwm_mo_steer #(.DEL_W(DEL_W), .RST_POL(RST_POL)) u_steer (
      .clk(clk), .rst(rst), .en(en), .run(run), .raw(raw),
      .mode(ctl_a.mode), .pol(ctl_a.pol), .del_a(del_a), .del_sh(del_sh),
      .duty_fall(duty_fall), .phase_q(phase_q), .pwm_out(pwm_out)
   );

   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
      (en && duty_a == '0) |=> !phase_q) else $error("pulse with zero duty"); // R4
endmodule

// File: tb/sim_pwm_multi_out.sv
module sim_pwm_multi_out;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [9:0] wr_data = '0;
   logic [3:0] pwm_out;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   string cur_req = "R1";

   pwm_multi_out u0 (
      .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   always #(CLK_PER/2) clk = ~clk;

   // behavioural reference
   int s_per, s_duty, s_ctl, s_del;
   int a_per, a_duty, a_pre, a_mode, a_pol, a_del;
   int ps, ph, tm, run, rq, dc, m_out;

   function automatic int act_of(int md, int r, int q, int d);
      case (md)
         0: return q;
         1: return r | (q << 3);
         2: return ((q != 0 && d == 0) ? 1 : 0) | ((r != 0 && q == 0 && d == 0) ? 2 : 0);
         default: return (r << 2) | (q << 1);
      endcase
   endfunction

   always @(posedge clk) begin
      int nout, raw, pmax, tick, wrp, fall;
      cyc++;
      if (rst) begin
         s_per = 0; s_duty = 0; s_ctl = 0; s_del = 0;
         a_per = 0; a_duty = 0; a_pre = 0; a_mode = 0; a_pol = 0; a_del = 0;
         ps = 0; ph = 0; tm = 0; run = 0; rq = 0; dc = 0; m_out = 0;
      end else begin
         nout = act_of(a_mode, run, rq, dc) ^ a_pol;
         raw = (run != 0 && (tm * 4 + ph) < a_duty) ? 1 : 0;
         if (!en) begin
            ps = 0; ph = 0; tm = 0; run = 0; rq = 0; dc = 0;
            a_per = s_per; a_duty = s_duty; a_del = s_del;
            a_pre = s_ctl & 3; a_mode = (s_ctl >> 2) & 3; a_pol = (s_ctl >> 4) & 15;
         end else begin
            pmax = (a_pre == 0) ? 0 : (a_pre == 1) ? 3 : 15;
            tick = (ps == pmax) ? 1 : 0;
            wrp = (tick != 0 && ph == 3 && tm == a_per) ? 1 : 0;
            fall = (rq != 0 && raw == 0) ? 1 : 0;
            if (raw != rq) dc = fall ? s_del : a_del;
            else if (dc > 0) dc--;
            rq = raw;
            if (tick) begin
               ps = 0;
               if (ph == 3) begin ph = 0; tm = wrp ? 0 : tm + 1; end
               else ph++;
            end else ps++;
            if (wrp) begin
               run = 1;
               a_per = s_per; a_duty = s_duty; a_del = s_del;
               a_pre = s_ctl & 3; a_mode = (s_ctl >> 2) & 3; a_pol = (s_ctl >> 4) & 15;
            end else if (fall) a_del = s_del;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: s_per = wr_data & 255;
               2'd1: s_duty = wr_data;
               2'd2: s_ctl = wr_data & 255;
               default: s_del = wr_data & 127;
            endcase
         end
         m_out = nout;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         checks++;
         if (pwm_out != m_out[3:0]) begin
            fails++;
            $display("FAIL %s model cycle %0d: actual=%b expected=%b", cur_req, cyc, pwm_out, m_out[3:0]);
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R7 watchdog: actual=%0d cycles expected<150000", cyc);
         summary();
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, int val);
      wr_sel = sel; wr_data = val[9:0]; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rise(int b);
      logic prev;
      prev = pwm_out[b];
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (pwm_out[b] && !prev) break;
         prev = pwm_out[b];
      end
   endtask

   task automatic wait_fall(int b);
      logic prev;
      prev = pwm_out[b];
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (!pwm_out[b] && prev) break;
         prev = pwm_out[b];
      end
   endtask

   task automatic meas(int b, output int per_c, output int hi_c);
      logic prev;
      wait_rise(b);
      per_c = 0; hi_c = 0;
      for (int i = 0; i < 5000; i++) begin
         per_c++;
         if (pwm_out[b]) hi_c++;
         prev = pwm_out[b];
         @(negedge clk);
         if (pwm_out[b] && !prev) break;
      end
   endtask

   task automatic count_hi(int b, int n, output int hi_c);
      hi_c = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out[b]) hi_c++;
         @(negedge clk);
      end
   endtask

   task automatic gap(output int g);
      g = 0;
      for (int i = 0; i < 500 && pwm_out[1:0] == 2'b00; i++) begin
         g++;
         @(negedge clk);
      end
   endtask

   initial begin
      int p, h, h2, n, g;
      idle(3);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset outputs", int'(pwm_out), 0);

      cur_req = "R5";
      wr(2'd0, 4); wr(2'd1, 9); wr(2'd2, 8'h00); wr(2'd3, 0);
      idle(2);

      cur_req = "R7";
      en = 1'b1;
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (pwm_out[0]) break;
      end
      chk("R7 first pulse delay", n, 22);

      cur_req = "R2";
      meas(0, p, h);
      chk("R2 period pre1", p, 20);
      chk("R3 high time", h, 9);

      cur_req = "R5";
      wait_rise(0);
      wr_sel = 2'd1; wr_data = 10'd5; wr_en = 1'b1;
      h = 1;
      @(negedge clk);
      wr_en = 1'b0;
      while (pwm_out[0] && h < 100) begin h++; @(negedge clk); end
      chk("R5 current pulse keeps old duty", h, 9);
      meas(0, p, h);
      chk("R5 next pulse uses new duty", h, 5);

      cur_req = "R2";
      wr(2'd0, 2); wr(2'd1, 5); wr(2'd2, 8'h01);
      meas(0, p, h);
      chk("R2 period pre4", p, 48);
      chk("R3 high time pre4", h, 20);
      wr(2'd0, 0); wr(2'd1, 2); wr(2'd2, 8'h02);
      meas(0, p, h);
      chk("R2 period pre16", p, 64);
      chk("R3 high time pre16", h, 32);

      cur_req = "R4";
      wr(2'd2, 8'h00); wr(2'd0, 4); wr(2'd1, 0);
      idle(150);
      count_hi(0, 40, h);
      chk("R4 zero duty never active", h, 0);

      cur_req = "R3";
      wr(2'd1, 1023);
      idle(60);
      count_hi(0, 40, h);
      chk("R3 duty beyond period stays active", h, 40);

      cur_req = "R9";
      wr(2'd1, 9); wr(2'd2, 8'hF0);
      idle(60);
      chk("R9 unused outputs read 1", int'(pwm_out[3:1]), 7);
      count_hi(0, 40, h);
      chk("R9 inverted A high count", h, 22);

      cur_req = "R8";
      wr(2'd2, 8'h04);
      idle(60);
      count_hi(0, 40, h);
      chk("R8 fwd A held", h, 40);
      count_hi(3, 40, h);
      chk("R8 fwd D pulses", h, 18);
      chk("R8 fwd B C idle", int'(pwm_out[2:1]), 0);
      wr(2'd2, 8'h0C);
      idle(60);
      count_hi(2, 40, h);
      chk("R8 rev C held", h, 40);
      count_hi(1, 40, h2);
      chk("R8 rev B pulses", h2, 18);
      chk("R8 rev A D idle", int'({pwm_out[3], pwm_out[0]}), 0);

      cur_req = "R10";
      wr(2'd2, 8'h08); wr(2'd3, 3);
      idle(60);
      wait_fall(0);
      gap(g);
      chk("R10 dead time after A falls", g, 3);
      wait_fall(1);
      gap(g);
      chk("R10 dead time before A rises", g, 3);

      cur_req = "R6";
      wait_rise(0);
      wr(2'd3, 1);
      wait_fall(0);
      gap(g);
      chk("R6 delay adopted at duty fall", g, 1);
      wait_fall(1);
      gap(g);
      chk("R6 delay kept at next edge", g, 1);

      idle(5);
      summary();
   end
endmodule